// File: doc/BRIEF.md
# Flash Serial-Programming Command Engine

This block sits between a programmer's control logic and a byte-wide serial master that talks to a target microcontroller's in-system programming port. It takes three kinds of flash request: byte read, byte load/write, and page commit. It expands each request into four-byte command frames and hands them one byte at a time to the serial master. Each read frame's last reply becomes the read data.

Targets with more than 128 KiB of flash need an extended address byte. The engine keeps the last extended byte it sent. It emits a load-extended-address frame only when bits 17 and up of a new request's address differ from that stored value.

After a write or a page commit, the engine confirms completion in one of two ways. It either waits a fixed number of timing intervals, or it re-reads the same location until the reply differs from a sentinel byte. Polling has a retry budget counted in elapsed intervals. When that budget runs out, the error output is raised. While a request is in progress, busy stays high.

Top module: `isp_flash_cmd_engine`

## Requirements
- R1: Out of reset, busy, error and the serial request are low. A request with kind 0 (read), 1 (write) or 2 (commit) that arrives while busy is low is accepted, and busy is high in the next cycle. Kind 3 is ignored: busy stays low and no byte is sent.
- R2: A read sends the frame {0x20 with bit 3 equal to address bit 0, address[16:9], address[8:1], 0x00}. The reply to the fourth byte appears on the read-data output when busy falls.
- R3: The stored extended byte resets to 0. When address[ADDR_W-1:17] of an accepted request differs from the stored byte, the frame {0x4D, 0x00, new byte, 0x00} is sent first and the byte is stored. Otherwise no such frame is sent.
- R4: A write sends {0x40 with bit 3 equal to address bit 0, address[16:9], address[8:1], data}. With poll mode off, busy falls right after that frame, with no further bytes.
- R5: A write with poll mode on and data 0x7F sends no read-back. Busy stays high for FIXED_WAIT_INTERVALS intervals after the frame.
- R6: A write with poll mode on and other data reads the same address repeatedly. It finishes without error at the first reply that is not 0x7F.
- R7: While polling, each elapsed interval of INTERVAL_CYCLES clocks consumes one of RETRY_BUDGET retries. A read that is in flight is not cut short. If a sentinel reply arrives after the budget is exhausted, error is raised and busy falls.
- R8: A page commit sends {0x4C, address[16:9], address[8:1], 0x00}. If the poll value is 0xFF, it waits a fixed FIXED_WAIT_INTERVALS intervals without reading.
- R9: A page commit with any other poll value polls until a reply differs from 0xFF, under the same retry budget as R7.
- R10: Error holds until the next request is accepted, and is cleared when that request starts.
- R11: The serial request stays high with its byte unchanged until the done strobe. The serial request is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_kind | input | 2 | 0 read, 1 write, 2 page commit, 3 ignored |
| req_addr | input | ADDR_W | Flash byte address |
| req_data | input | 8 | Byte to write |
| req_poll | input | 1 | Write completion check enable |
| req_pollval | input | 8 | Page-commit poll value (0xFF selects fixed wait) |
| busy | output | 1 | Request in progress |
| err_o | output | 1 | Last request ran out of retries |
| rd_data | output | 8 | Reply to the last read frame |
| sm_valid | output | 1 | Byte ready for the serial master |
| sm_tx | output | 8 | Byte to shift out |
| sm_done | input | 1 | One-cycle strobe: byte exchanged |
| sm_rx | input | 8 | Byte shifted in, valid with sm_done |

## Verification
The bench builds the engine with a 24-bit address, an interval of 40 clocks, a retry budget of 3 and a fixed wait of 4 intervals. These values keep the fixed-wait and exhausted-budget paths to a few hundred cycles, so the bench can measure busy time against exact interval multiples. The serial-master model answers every byte after a short latency. Its scripted replies let polling succeed after a chosen number of sentinel replies, or never succeed. With a 24-bit address, the extended byte can move away from 0 and back again.

// File: rtl/isp_eng_pkg.sv
package isp_eng_pkg;

   typedef enum logic [1:0] {
      KIND_READ   = 2'd0,
      KIND_WRITE  = 2'd1,
      KIND_COMMIT = 2'd2,
      KIND_NONE   = 2'd3
   } req_kind_t;

   typedef enum logic [1:0] {
      FR_XADDR  = 2'd0,
      FR_READ   = 2'd1,
      FR_WRITE  = 2'd2,
      FR_COMMIT = 2'd3
   } frame_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_HOLD = 2'd2
   } eng_state_t;

   localparam logic [7:0] OP_XADDR   = 8'h4D;
   localparam logic [7:0] OP_READ    = 8'h20;
   localparam logic [7:0] OP_WRITE   = 8'h40;
   localparam logic [7:0] OP_COMMIT  = 8'h4C;
   localparam logic [7:0] WR_MARK    = 8'h7F;
   localparam logic [7:0] ERASED_VAL = 8'hFF;

endpackage

// File: rtl/isp_ext_tracker.sv
module isp_ext_tracker #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              probe,
   output logic              need_load,
   output logic [7:0]        ext_byte
);
   localparam int XW = ADDR_W - 17;

   initial begin
      if (XW < 1 || XW > 8) $error("ADDR_W must be in 18..25");
   end

   logic [7:0] stored_q;

   generate
      if (XW == 8) begin : g_full
         assign ext_byte = addr[ADDR_W-1:17];
      end else begin : g_pad
         assign ext_byte = {{(8-XW){1'b0}}, addr[ADDR_W-1:17]};
      end
   endgenerate

   assign need_load = (ext_byte != stored_q);

   always_ff @(posedge clk) begin
      if (!rst_n)                 stored_q <= 8'h00;
      else if (probe && need_load) stored_q <= ext_byte;
   end

   // R3
   ext_tracks_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      probe |=> !need_load || (ext_byte != $past(ext_byte)));

endmodule

// File: rtl/isp_frame_mux.sv
module isp_frame_mux #(
   parameter int ADDR_W = 24
) (
   input  isp_eng_pkg::frame_t frame,
   input  logic [1:0]          idx,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          data,
   input  logic [7:0]          ext_byte,
   output logic [7:0]          tx_byte
);
   import isp_eng_pkg::*;

   initial begin
      if (ADDR_W < 18) $error("ADDR_W too small for frame addressing");
   end

   logic [7:0] hi_a, lo_a, rd_op, wr_op;

   always_comb begin
      hi_a  = addr[16:9];
      lo_a  = addr[8:1];
      rd_op = OP_READ  | {4'b0, addr[0], 3'b0};
      wr_op = OP_WRITE | {4'b0, addr[0], 3'b0};
      tx_byte = 8'h00;
      unique case (frame)
         FR_XADDR: begin
            case (idx)
               2'd0:    tx_byte = OP_XADDR;
               2'd2:    tx_byte = ext_byte;
               default: tx_byte = 8'h00;
            endcase
         end
         FR_READ: begin
            case (idx)
               2'd0:    tx_byte = rd_op;
               2'd1:    tx_byte = hi_a;
               2'd2:    tx_byte = lo_a;
               default: tx_byte = 8'h00;
            endcase
         end
         FR_WRITE: begin
            case (idx)
               2'd0:    tx_byte = wr_op;
               2'd1:    tx_byte = hi_a;
               2'd2:    tx_byte = lo_a;
               default: tx_byte = data;
            endcase
         end
         FR_COMMIT: begin
            case (idx)
               2'd0:    tx_byte = OP_COMMIT;
               2'd1:    tx_byte = hi_a;
               2'd2:    tx_byte = lo_a;
               default: tx_byte = 8'h00;
            endcase
         end
         default: tx_byte = 8'h00;
      endcase
   end

endmodule

// File: rtl/isp_interval_timer.sv
module isp_interval_timer #(
   parameter int INTERVAL_CYCLES = 3840
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   output logic tick
);
   localparam int CW = $clog2(INTERVAL_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYCLES - 1);

   initial begin
      if (INTERVAL_CYCLES < 2) $error("INTERVAL_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign tick = en && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  cnt_q <= '0;
      else if (en) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7
   restart_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick);

endmodule

// File: rtl/isp_flash_cmd_engine.sv
module isp_flash_cmd_engine #(
   parameter int ADDR_W               = 24,
   parameter int INTERVAL_CYCLES      = 3840,
   parameter int RETRY_BUDGET         = 30,
   parameter int FIXED_WAIT_INTERVALS = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   input  logic              req_poll,
   input  logic [7:0]        req_pollval,
   output logic              busy,
   output logic              err_o,
   output logic [7:0]        rd_data,
   output logic              sm_valid,
   output logic [7:0]        sm_tx,
   input  logic              sm_done,
   input  logic [7:0]        sm_rx
);
   import isp_eng_pkg::*;

   localparam int CNT_MAX = (RETRY_BUDGET > FIXED_WAIT_INTERVALS) ?
                            RETRY_BUDGET : FIXED_WAIT_INTERVALS;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] RETRY_INIT = CNT_W'(RETRY_BUDGET);
   localparam logic [CNT_W-1:0] WAIT_INIT  = CNT_W'(FIXED_WAIT_INTERVALS);

   initial begin
      if (RETRY_BUDGET < 1)         $error("RETRY_BUDGET must be positive");
      if (FIXED_WAIT_INTERVALS < 1) $error("FIXED_WAIT_INTERVALS must be positive");
   end

   eng_state_t        state_q;
   frame_t            frame_q;
   req_kind_t         kind_q;
   logic [1:0]        idx_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic              poll_q;
   logic [7:0]        pollval_q;
   logic              polling_q;
   logic [7:0]        sentinel_q;
   logic [CNT_W-1:0]  left_q;
   logic              err_q;
   logic [7:0]        rd_q;

   logic        accept, need_load, frame_end, tick, tmr_en, tmr_clr;
   logic [7:0]  ext_byte, ext_q, tx_byte;
   frame_t      main_frame;

   assign accept    = (state_q == ST_IDLE) && req_valid && (req_kind != KIND_NONE);
   assign frame_end = (state_q == ST_SEND) && sm_done && (idx_q == 2'd3);
   assign tmr_en    = polling_q || (state_q == ST_HOLD);
   assign tmr_clr   = frame_end &&
                      (((frame_q == FR_WRITE) && poll_q) || (frame_q == FR_COMMIT));

   always_comb begin
      unique case (kind_q)
         KIND_WRITE:  main_frame = FR_WRITE;
         KIND_COMMIT: main_frame = FR_COMMIT;
         default:     main_frame = FR_READ;
      endcase
   end

   isp_ext_tracker #(.ADDR_W(ADDR_W)) ext_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (req_addr),
      .probe     (accept),
      .need_load (need_load),
      .ext_byte  (ext_byte)
   );

   isp_frame_mux #(.ADDR_W(ADDR_W)) mux_i (
      .frame    (frame_q),
      .idx      (idx_q),
      .addr     (addr_q),
      .data     (data_q),
      .ext_byte (ext_q),
      .tx_byte  (tx_byte)
   );

   isp_interval_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) tmr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tmr_en),
      .clr   (tmr_clr),
      .tick  (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         frame_q    <= FR_READ;
         kind_q     <= KIND_READ;
         idx_q      <= 2'd0;
         addr_q     <= '0;
         data_q     <= 8'h00;
         poll_q     <= 1'b0;
         pollval_q  <= 8'h00;
         polling_q  <= 1'b0;
         sentinel_q <= 8'h00;
         left_q     <= '0;
         err_q      <= 1'b0;
         rd_q       <= 8'h00;
         ext_q      <= 8'h00;
      end else begin
         if (tick && left_q != '0) left_q <= left_q - 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  kind_q    <= req_kind_t'(req_kind);
                  addr_q    <= req_addr;
                  data_q    <= req_data;
                  poll_q    <= req_poll;
                  pollval_q <= req_pollval;
                  ext_q     <= ext_byte;
                  err_q     <= 1'b0;
                  idx_q     <= 2'd0;
                  state_q   <= ST_SEND;
                  if (need_load) frame_q <= FR_XADDR;
                  else begin
                     unique case (req_kind_t'(req_kind))
                        KIND_WRITE:  frame_q <= FR_WRITE;
                        KIND_COMMIT: frame_q <= FR_COMMIT;
                        default:     frame_q <= FR_READ;
                     endcase
                  end
               end
            end
            ST_SEND: begin
               if (sm_done) idx_q <= idx_q + 2'd1;
               if (frame_end) begin
                  unique case (frame_q)
                     FR_XADDR: frame_q <= main_frame;
                     FR_READ: begin
                        rd_q <= sm_rx;
                        if (!polling_q || sm_rx != sentinel_q) begin
                           polling_q <= 1'b0;
                           state_q   <= ST_IDLE;
                        end else if (left_q == '0) begin
                           polling_q <= 1'b0;
                           err_q     <= 1'b1;
                           state_q   <= ST_IDLE;
                        end
                     end
                     FR_WRITE: begin
                        if (!poll_q) state_q <= ST_IDLE;
                        else if (data_q == WR_MARK) begin
                           left_q  <= WAIT_INIT;
                           state_q <= ST_HOLD;
                        end else begin
                           polling_q  <= 1'b1;
                           sentinel_q <= WR_MARK;
                           left_q     <= RETRY_INIT;
                           frame_q    <= FR_READ;
                        end
                     end
                     default: begin
                        if (pollval_q == ERASED_VAL) begin
                           left_q  <= WAIT_INIT;
                           state_q <= ST_HOLD;
                        end else begin
                           polling_q  <= 1'b1;
                           sentinel_q <= ERASED_VAL;
                           left_q     <= RETRY_INIT;
                           frame_q    <= FR_READ;
                        end
                     end
                  endcase
               end
            end
            ST_HOLD: begin
               if (tick && left_q == CNT_W'(1)) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign err_o    = err_q;
   assign rd_data  = rd_q;
   assign sm_valid = (state_q == ST_SEND);
   assign sm_tx    = tx_byte;

   // R1
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_kind != 2'd3) |=> busy);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sm_valid);

   // R11
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sm_valid && !sm_done) |=> (sm_valid && $stable(sm_tx)));

   // R7
   budget_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (polling_q && $past(polling_q)) |-> (left_q <= $past(left_q)));

   // R10
   err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $fell(busy));

endmodule

// File: tb/isp_flash_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module isp_flash_cmd_engine_tb_top;

   localparam int AW   = 24;
   localparam int IVL  = 40;
   localparam int RB   = 3;
   localparam int FW   = 4;
   localparam int LAT  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = 8'h00;
   logic          req_poll = 1'b0;
   logic [7:0]    req_pollval = 8'h00;
   logic          busy, err_o, sm_valid;
   logic [7:0]    rd_data, sm_tx;
   logic          sm_done = 1'b0;
   logic [7:0]    sm_rx = 8'h00;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   isp_flash_cmd_engine #(
      .ADDR_W(AW), .INTERVAL_CYCLES(IVL),
      .RETRY_BUDGET(RB), .FIXED_WAIT_INTERVALS(FW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_data(req_data), .req_poll(req_poll),
      .req_pollval(req_pollval), .busy(busy), .err_o(err_o), .rd_data(rd_data),
      .sm_valid(sm_valid), .sm_tx(sm_tx), .sm_done(sm_done), .sm_rx(sm_rx)
   );

   // serial master model
   logic [7:0] byte_log [0:1023];
   int         nlog   = 0;
   int         nreads = 0;
   int         lat    = 0;
   int         pos    = 0;
   logic [7:0] first_b = 8'h00;
   // scripted replies (written by tasks only)
   int         reads_base = 0;
   int         sent_count = 0;
   logic [7:0] sent_val   = 8'h00;
   logic [7:0] final_val  = 8'h00;

   always @(posedge clk) begin
      if (!rst_n) begin
         sm_done <= 1'b0;
         lat     <= 0;
         pos     <= 0;
      end else if (sm_done) begin
         sm_done <= 1'b0;
      end else if (sm_valid) begin
         if (lat == LAT - 1) begin
            lat     <= 0;
            sm_done <= 1'b1;
            if (nlog < 1024) byte_log[nlog] <= sm_tx;
            nlog    <= nlog + 1;
            pos     <= (pos + 1) % 4;
            if (pos == 0) first_b <= sm_tx;
            if (pos == 3 && (first_b & 8'hF7) == 8'h20) begin
               nreads <= nreads + 1;
               sm_rx  <= ((nreads - reads_base) < sent_count) ? sent_val : final_val;
            end else begin
               sm_rx <= 8'h00;
            end
         end else begin
            lat <= lat + 1;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_range(input string tag, input int act, input int lo, input int hi);
      n_checks++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic chk_frame(input string tag, input int at,
                            input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3);
      chk({tag, " byte0"}, byte_log[at],   b0);
      chk({tag, " byte1"}, byte_log[at+1], b1);
      chk({tag, " byte2"}, byte_log[at+2], b2);
      chk({tag, " byte3"}, byte_log[at+3], b3);
   endtask

   task automatic script(input int cnt, input logic [7:0] sv, input logic [7:0] fv);
      reads_base = nreads;
      sent_count = cnt;
      sent_val   = sv;
      final_val  = fv;
   endtask

   // issues one request, returns busy cycle count
   task automatic run_req(input logic [1:0] kind, input logic [AW-1:0] a,
                          input logic [7:0] d, input logic pl, input logic [7:0] pv,
                          output int cycles);
      @(negedge clk);
      req_kind = kind; req_addr = a; req_data = d; req_poll = pl; req_pollval = pv;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cycles = 1;
      // R1 accepted request raises busy
      chk("R1 busy after accept", busy, 1);
      while (busy && cycles < 5000) begin
         @(negedge clk);
         cycles++;
      end
      if (busy) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: busy stuck, actual 1 expected 0");
      end
   endtask

   task automatic t_reset;
      chk("R1 reset busy", busy, 0);
      chk("R1 reset err", err_o, 0);
      chk("R11 reset sm_valid", sm_valid, 0);
   endtask

   task automatic t_read_plain;
      int base, cyc;
      base = nlog;
      script(0, 8'h00, 8'hA5);
      run_req(2'd0, 24'h000005, 8'h00, 1'b0, 8'h00, cyc);
      chk("R3 no ext frame count", nlog - base, 4);
      chk_frame("R2 read odd", base, 8'h28, 8'h00, 8'h02, 8'h00);
      chk("R2 rd_data", rd_data, 8'hA5);
   endtask

   task automatic t_read_ext;
      int base, cyc;
      base = nlog;
      script(0, 8'h00, 8'h3C);
      run_req(2'd0, 24'h060404, 8'h00, 1'b0, 8'h00, cyc);
      chk("R3 ext frame count", nlog - base, 8);
      chk_frame("R3 ext frame", base, 8'h4D, 8'h00, 8'h03, 8'h00);
      chk_frame("R2 read even", base + 4, 8'h20, 8'h02, 8'h02, 8'h00);
      chk("R2 rd_data ext", rd_data, 8'h3C);
      base = nlog;
      run_req(2'd0, 24'h061000, 8'h00, 1'b0, 8'h00, cyc);
      chk("R3 same ext suppressed", nlog - base, 4);
   endtask

   task automatic t_ignored;
      int base;
      base = nlog;
      @(negedge clk);
      req_kind = 2'd3; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 kind3 ignored busy", busy, 0);
      repeat (10) @(negedge clk);
      chk("R1 kind3 no bytes", nlog - base, 0);
   endtask

   task automatic t_write_nopoll;
      int base, cyc;
      base = nlog;
      run_req(2'd1, 24'h060003, 8'h12, 1'b0, 8'h00, cyc);
      chk("R4 write frame count", nlog - base, 4);
      chk_frame("R4 write", base, 8'h48, 8'h00, 8'h01, 8'h12);
      chk_range("R4 prompt finish", cyc, 4, 20);
   endtask

   task automatic t_write_fixed;
      int base, cyc;
      base = nlog;
      run_req(2'd1, 24'h060002, 8'h7F, 1'b1, 8'h00, cyc);
      chk("R5 no readback", nlog - base, 4);
      chk_range("R5 fixed wait time", cyc, FW * IVL, FW * IVL + 30);
   endtask

   task automatic t_write_poll;
      int base, cyc;
      base = nlog;
      script(2, 8'h7F, 8'h55);
      run_req(2'd1, 24'h060002, 8'h55, 1'b1, 8'h00, cyc);
      chk("R6 poll byte count", nlog - base, 16);
      chk_frame("R6 poll read", base + 4, 8'h20, 8'h00, 8'h01, 8'h00);
      chk("R6 no error", err_o, 0);
   endtask

   task automatic t_write_timeout;
      int cyc, r0;
      script(100000, 8'h7F, 8'h7F);
      r0 = nreads;
      run_req(2'd1, 24'h060002, 8'h11, 1'b1, 8'h00, cyc);
      chk("R7 error on budget", err_o, 1);
      chk_range("R7 budget time", cyc, RB * IVL, RB * IVL + 40);
      chk_range("R7 reads made", nreads - r0, 2, 100);
      repeat (5) @(negedge clk);
      chk("R10 error held", err_o, 1);
   endtask

   task automatic t_err_clear;
      int cyc;
      script(0, 8'h00, 8'h66);
      @(negedge clk);
      req_kind = 2'd0; req_addr = 24'h060002; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 error cleared at start", err_o, 0);
      cyc = 0;
      while (busy && cyc < 5000) begin @(negedge clk); cyc++; end
      chk("R10 rd after clear", rd_data, 8'h66);
   endtask

   task automatic t_commit_fixed;
      int base, cyc;
      base = nlog;
      run_req(2'd2, 24'h060200, 8'h00, 1'b0, 8'hFF, cyc);
      chk("R8 commit count", nlog - base, 4);
      chk_frame("R8 commit", base, 8'h4C, 8'h01, 8'h00, 8'h00);
      chk_range("R8 fixed wait time", cyc, FW * IVL, FW * IVL + 30);
   endtask

   task automatic t_commit_poll;
      int base, cyc;
      base = nlog;
      script(1, 8'hFF, 8'h00);
      run_req(2'd2, 24'h060200, 8'h00, 1'b0, 8'h00, cyc);
      chk("R9 poll byte count", nlog - base, 12);
      chk_frame("R9 poll read", base + 4, 8'h20, 8'h01, 8'h00, 8'h00);
      chk("R9 no error", err_o, 0);
      script(100000, 8'hFF, 8'hFF);
      run_req(2'd2, 24'h060200, 8'h00, 1'b0, 8'h00, cyc);
      chk("R9 budget error", err_o, 1);
   endtask

   task automatic t_ext_back;
      int base, cyc;
      base = nlog;
      script(0, 8'h00, 8'h01);
      run_req(2'd0, 24'h000010, 8'h00, 1'b0, 8'h00, cyc);
      chk("R3 ext back to zero count", nlog - base, 8);
      chk_frame("R3 ext zero", base, 8'h4D, 8'h00, 8'h00, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_read_plain();
      t_read_ext();
      t_ignored();
      t_write_nopoll();
      t_write_fixed();
      t_write_poll();
      t_write_timeout();
      t_err_clear();
      t_commit_fixed();
      t_commit_poll();
      t_ext_back();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule